// File: doc/BRIEF.md
# Cluster Hub Coherence Directory Controller

This block sits in the hub node of a processor cluster, beside the shared second-level cache that holds a superset of every line cached by the cluster members. For each line of that cache it keeps a full-map record: one presence flag per member, a flag for a member holding the line modified, a flag for the hub holding a valid copy, and a flag for the cluster owning the line for writing. Member reads and writes are served inside the cluster when this record allows it. Otherwise the hub sends one request to the home directory, and reads from other members for the same line ride on that request.

Invalidations from the home, and evictions chosen by the hub's own replacement logic, are fanned out only to members whose presence flag is set. Their acknowledgements are gathered into a single reply upward. When the home grants write permission to this cluster, the hub first clears the copies held by other local sharers and then passes the permission to the member that asked. While one transaction is in flight, a single further command is parked in a one-entry slot.

Top module: `hub_dir_ctrl`

## Requirements
- R1: A directory entry never records a member-modified line with more than one member present; after a member write, the only copy a later reader invalidates is the writer's.
- R2: A read of a line the hub holds, with no member holding it modified, is granted to the requester with no home message and no invalidation.
- R3: A read of a line the hub does not hold sends exactly one home request of kind read (hreq_kind 0). Reads of that line by other members while the home reply is pending are merged and do not add a request. Every merged reader receives a read grant, in ascending member order, after hgrant_valid.
- R4: A home invalidation sends one member invalidation to each present member in ascending member order. After all of them acknowledge, it returns one hack_valid pulse carrying the line and clears the entry, so the next read of that line misses.
- R5: A home invalidation for a line with no member present returns hack_valid without any member invalidation.
- R6: A write to a line the cluster does not own sends one home request of kind write (hreq_kind 1). On hgrant_valid the hub invalidates every other local sharer, and only after their acknowledgements grants write permission (mgrant_write 1) to the requester.
- R7: A write to a line the cluster already owns is resolved inside the cluster. The other local sharers are invalidated, then the write is granted, with no home message.
- R8: A read of a line held modified by another member invalidates that member first, then grants the read, with no home message.
- R9: An eviction invalidates every present member. After their acknowledgements it sends one home message of kind evict (hreq_kind 2) and clears the entry.
- R10: Member identifiers at or above the member count are ignored. A request with such an identifier produces no output, and an acknowledgement with such an identifier does not complete a fan-in.
- R11: While a transaction is in flight, one command for a different line is accepted into a pending slot and served once the current one finishes. While the slot is full, mreq_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_valid | input | 1 | Member request present |
| mreq_ready | output | 1 | Member request accepted this cycle |
| mreq_id | input | IDW | Requesting member |
| mreq_line | input | LW | Line index of the request |
| mreq_write | input | 1 | 1 for write, 0 for read |
| minv_valid | output | 1 | Invalidation to a member |
| minv_id | output | IDW | Member being invalidated |
| minv_line | output | LW | Line being invalidated |
| mack_valid | input | 1 | Member invalidation acknowledge |
| mack_id | input | IDW | Acknowledging member |
| mgrant_valid | output | 1 | Grant to a member |
| mgrant_id | output | IDW | Member receiving the grant |
| mgrant_line | output | LW | Granted line |
| mgrant_write | output | 1 | 1 for write permission, 0 for read |
| hinv_valid | input | 1 | Invalidation from the home directory |
| hinv_ready | output | 1 | Home invalidation accepted |
| hinv_line | input | LW | Line to invalidate |
| evict_valid | input | 1 | Hub cache eviction command |
| evict_ready | output | 1 | Eviction accepted |
| evict_line | input | LW | Line being evicted |
| hreq_valid | output | 1 | Message to the home directory |
| hreq_kind | output | 2 | 0 read, 1 write, 2 evict |
| hreq_line | output | LW | Line of the home message |
| hgrant_valid | input | 1 | Home reply to the pending request |
| hack_valid | output | 1 | Combined acknowledgement to the home |
| hack_line | output | LW | Line acknowledged |

## Verification
Requests are applied in sequences that build distinct directory states: a single sharer, several sharers, one member holding the line modified, and an owned line with extra readers. A hit, a miss, an owned write and an unowned write can therefore be told apart by whether a home message appears and which members are invalidated. Home invalidations are sent both with sharers present and with none, which separates the fan-out path from the immediate reply. Overlapping reads of one line check that they merge into one home request. A second request for another line checks that it is held back rather than merged. Out-of-range identifiers are sent both as requests and as acknowledgements, to show that neither produces a grant nor completes a fan-in early.

// File: rtl/hub_dir_pkg.sv
package hub_dir_pkg;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_HINV  = 2'd2,
    OP_EVICT = 2'd3
  } hub_op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HREQ  = 3'd1,
    S_HWAIT = 3'd2,
    S_FAN   = 3'd3,
    S_FIN   = 3'd4,
    S_GRANT = 3'd5
  } hub_st_e;

  localparam logic [1:0] HK_READ  = 2'd0;
  localparam logic [1:0] HK_WRITE = 2'd1;
  localparam logic [1:0] HK_EVICT = 2'd2;

endpackage

// File: rtl/hub_id_decode.sv
module hub_id_decode #(
  parameter int NMEM = 9,
  localparam int IDW = $clog2(NMEM)
) (
  input  logic            en,
  input  logic [IDW-1:0]  id,
  output logic [NMEM-1:0] onehot
);

  // Identifiers at or above NMEM select no bit.
  for (genvar gi = 0; gi < NMEM; gi++) begin : g_bit
    assign onehot[gi] = en && (id == IDW'(gi));
  end

endmodule

// File: rtl/hub_first_set.sv
module hub_first_set #(
  parameter int W = 9,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/hub_dir_table.sv
module hub_dir_table #(
  parameter int NMEM   = 9,
  parameter int NLINES = 16,
  localparam int LW = $clog2(NLINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   rd_line,
  output logic [NMEM-1:0] rd_pres,
  output logic            rd_dirty,
  output logic            rd_hv,
  output logic            rd_own,
  input  logic            wr_en,
  input  logic [LW-1:0]   wr_line,
  input  logic [NMEM-1:0] wr_pres,
  input  logic            wr_dirty,
  input  logic            wr_hv,
  input  logic            wr_own
);

  logic [NMEM-1:0] pres_q  [NLINES];
  logic            dirty_q [NLINES];
  logic            hv_q    [NLINES];
  logic            own_q   [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        pres_q[i]  <= '0;
        dirty_q[i] <= 1'b0;
        hv_q[i]    <= 1'b0;
        own_q[i]   <= 1'b0;
      end
    end else if (wr_en) begin
      pres_q[wr_line]  <= wr_pres;
      dirty_q[wr_line] <= wr_dirty;
      hv_q[wr_line]    <= wr_hv;
      own_q[wr_line]   <= wr_own;
    end
  end

  assign rd_pres  = pres_q[rd_line];
  assign rd_dirty = dirty_q[rd_line];
  assign rd_hv    = hv_q[rd_line];
  assign rd_own   = own_q[rd_line];

  // R1
  single_modifier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dirty |-> ($countones(rd_pres) == 1));

  // R1
  dirty_needs_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dirty) |-> (wr_hv && ($countones(wr_pres) == 1)));

endmodule

// File: rtl/hub_dir_ctrl.sv
module hub_dir_ctrl
  import hub_dir_pkg::*;
#(
  parameter int NMEM   = 9,
  parameter int NLINES = 16,
  localparam int IDW = $clog2(NMEM),
  localparam int LW  = $clog2(NLINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mreq_valid,
  output logic           mreq_ready,
  input  logic [IDW-1:0] mreq_id,
  input  logic [LW-1:0]  mreq_line,
  input  logic           mreq_write,
  output logic           minv_valid,
  output logic [IDW-1:0] minv_id,
  output logic [LW-1:0]  minv_line,
  input  logic           mack_valid,
  input  logic [IDW-1:0] mack_id,
  output logic           mgrant_valid,
  output logic [IDW-1:0] mgrant_id,
  output logic [LW-1:0]  mgrant_line,
  output logic           mgrant_write,
  input  logic           hinv_valid,
  output logic           hinv_ready,
  input  logic [LW-1:0]  hinv_line,
  input  logic           evict_valid,
  output logic           evict_ready,
  input  logic [LW-1:0]  evict_line,
  output logic           hreq_valid,
  output logic [1:0]     hreq_kind,
  output logic [LW-1:0]  hreq_line,
  input  logic           hgrant_valid,
  output logic           hack_valid,
  output logic [LW-1:0]  hack_line
);

  localparam logic [NMEM-1:0] ONE = NMEM'(1);

  // ---------------- registers ----------------
  hub_st_e         st_q, st_d;
  hub_op_e         op_q, op_d;
  logic [IDW-1:0]  id_q, id_d;
  logic [LW-1:0]   line_q, line_d;
  logic [NMEM-1:0] todo_q, todo_d;
  logic [NMEM-1:0] wait_q, wait_d;
  logic [NMEM-1:0] gmask_q, gmask_d;
  logic [NMEM-1:0] inv_q, inv_d;
  logic            slot_v_q, slot_v_d;
  hub_op_e         slot_op_q, slot_op_d;
  logic [IDW-1:0]  slot_id_q, slot_id_d;
  logic [LW-1:0]   slot_line_q, slot_line_d;

  // ---------------- directory ----------------
  logic [LW-1:0]   dir_rd_line;
  logic [NMEM-1:0] rd_pres;
  logic            rd_dirty, rd_hv, rd_own;
  logic            dir_wr_en;
  logic [NMEM-1:0] wr_pres;
  logic            wr_dirty, wr_hv, wr_own;

  // ---------------- input arbitration ----------------
  logic            id_ok, merge_ok, slot_free;
  logic            take_hinv, take_evict, take_mreq;
  logic            in_v;
  hub_op_e         in_op;
  logic [IDW-1:0]  in_id;
  logic [LW-1:0]   in_line;
  logic            cmd_v;
  hub_op_e         cmd_op;
  logic [IDW-1:0]  cmd_id;
  logic [LW-1:0]   cmd_line;
  logic [IDW-1:0]  dec_id;
  logic [NMEM-1:0] req_bit;
  logic [NMEM-1:0] ack_bit;
  logic [NMEM-1:0] todo_low;

  assign id_ok     = int'(mreq_id) < NMEM;
  assign slot_free = !slot_v_q;
  assign merge_ok  = (st_q == S_HWAIT) && (op_q == OP_RD) && mreq_valid &&
                     !mreq_write && id_ok && (mreq_line == line_q);

  assign hinv_ready  = slot_free;
  assign evict_ready = slot_free && !hinv_valid;
  assign mreq_ready  = !hinv_valid && !evict_valid && (slot_free || merge_ok);

  assign take_hinv  = hinv_valid && hinv_ready;
  assign take_evict = evict_valid && evict_ready;
  assign take_mreq  = mreq_valid && mreq_ready;

  always_comb begin
    in_v    = 1'b0;
    in_op   = OP_RD;
    in_id   = '0;
    in_line = mreq_line;
    if (take_hinv) begin
      in_v    = 1'b1;
      in_op   = OP_HINV;
      in_line = hinv_line;
    end else if (take_evict) begin
      in_v    = 1'b1;
      in_op   = OP_EVICT;
      in_line = evict_line;
    end else if (take_mreq && id_ok && !merge_ok) begin
      in_v    = 1'b1;
      in_op   = mreq_write ? OP_WR : OP_RD;
      in_id   = mreq_id;
    end
  end

  assign cmd_v    = (st_q == S_IDLE) && (slot_v_q || in_v);
  assign cmd_op   = slot_v_q ? slot_op_q   : in_op;
  assign cmd_id   = slot_v_q ? slot_id_q   : in_id;
  assign cmd_line = slot_v_q ? slot_line_q : in_line;

  assign dec_id      = (st_q == S_IDLE) ? cmd_id : mreq_id;
  assign dir_rd_line = (st_q == S_IDLE) ? cmd_line : line_q;
  assign todo_low    = todo_q & (~todo_q + ONE);

  hub_id_decode #(.NMEM(NMEM)) u_req_dec (
    .en     (1'b1),
    .id     (dec_id),
    .onehot (req_bit)
  );

  hub_id_decode #(.NMEM(NMEM)) u_ack_dec (
    .en     (mack_valid),
    .id     (mack_id),
    .onehot (ack_bit)
  );

  hub_first_set #(.W(NMEM)) u_inv_pick (
    .vec (todo_q),
    .idx (minv_id)
  );

  hub_first_set #(.W(NMEM)) u_grant_pick (
    .vec (gmask_q),
    .idx (mgrant_id)
  );

  hub_dir_table #(.NMEM(NMEM), .NLINES(NLINES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_line  (dir_rd_line),
    .rd_pres  (rd_pres),
    .rd_dirty (rd_dirty),
    .rd_hv    (rd_hv),
    .rd_own   (rd_own),
    .wr_en    (dir_wr_en),
    .wr_line  (line_q),
    .wr_pres  (wr_pres),
    .wr_dirty (wr_dirty),
    .wr_hv    (wr_hv),
    .wr_own   (wr_own)
  );

  // ---------------- next state ----------------
  always_comb begin
    st_d        = st_q;
    op_d        = op_q;
    id_d        = id_q;
    line_d      = line_q;
    todo_d      = todo_q;
    wait_d      = wait_q;
    gmask_d     = gmask_q;
    inv_d       = inv_q;
    slot_v_d    = slot_v_q;
    slot_op_d   = slot_op_q;
    slot_id_d   = slot_id_q;
    slot_line_d = slot_line_q;

    if (st_q == S_IDLE) begin
      slot_v_d = 1'b0;
    end else if (in_v) begin
      slot_v_d    = 1'b1;
      slot_op_d   = in_op;
      slot_id_d   = in_id;
      slot_line_d = in_line;
    end

    unique case (st_q)
      S_IDLE: begin
        if (cmd_v) begin
          op_d    = cmd_op;
          id_d    = cmd_id;
          line_d  = cmd_line;
          gmask_d = '0;
          inv_d   = '0;
          unique case (cmd_op)
            OP_HINV, OP_EVICT: begin
              inv_d = rd_pres;
              st_d  = S_FAN;
            end
            OP_RD: begin
              gmask_d = req_bit;
              if (rd_hv) begin
                inv_d = rd_dirty ? (rd_pres & ~req_bit) : '0;
                st_d  = S_FAN;
              end else begin
                st_d = S_HREQ;
              end
            end
            default: begin
              gmask_d = req_bit;
              if (rd_hv && rd_own) begin
                inv_d = rd_pres & ~req_bit;
                st_d  = S_FAN;
              end else begin
                st_d = S_HREQ;
              end
            end
          endcase
          todo_d = inv_d;
          wait_d = inv_d;
        end
      end
      S_HREQ: st_d = S_HWAIT;
      S_HWAIT: begin
        if (merge_ok) gmask_d = gmask_q | req_bit;
        if (hgrant_valid) begin
          inv_d  = (op_q == OP_WR) ? (rd_pres & ~gmask_q) : '0;
          todo_d = inv_d;
          wait_d = inv_d;
          st_d   = S_FAN;
        end
      end
      S_FAN: begin
        todo_d = todo_q & ~todo_low;
        wait_d = wait_q & ~ack_bit;
        if ((todo_q == '0) && (wait_q == '0)) st_d = S_FIN;
      end
      S_FIN: st_d = (gmask_q != '0) ? S_GRANT : S_IDLE;
      S_GRANT: begin
        gmask_d = gmask_q & (gmask_q - ONE);
        if (gmask_d == '0) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // ---------------- directory update ----------------
  always_comb begin
    dir_wr_en = (st_q == S_FIN);
    wr_pres   = '0;
    wr_dirty  = 1'b0;
    wr_hv     = 1'b0;
    wr_own    = 1'b0;
    unique case (op_q)
      OP_RD: begin
        wr_pres = (rd_pres & ~inv_q) | gmask_q;
        wr_hv   = 1'b1;
        wr_own  = rd_own;
      end
      OP_WR: begin
        wr_pres  = gmask_q;
        wr_dirty = 1'b1;
        wr_hv    = 1'b1;
        wr_own   = 1'b1;
      end
      default: ;
    endcase
  end

  // ---------------- outputs ----------------
  assign minv_valid   = (st_q == S_FAN) && (todo_q != '0);
  assign minv_line    = line_q;
  assign mgrant_valid = (st_q == S_GRANT);
  assign mgrant_line  = line_q;
  assign mgrant_write = (op_q == OP_WR);
  assign hreq_valid   = (st_q == S_HREQ) || ((st_q == S_FIN) && (op_q == OP_EVICT));
  assign hreq_kind    = (st_q == S_FIN) ? HK_EVICT :
                        ((op_q == OP_WR) ? HK_WRITE : HK_READ);
  assign hreq_line    = line_q;
  assign hack_valid   = (st_q == S_FIN) && (op_q == OP_HINV);
  assign hack_line    = line_q;

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      op_q        <= OP_RD;
      id_q        <= '0;
      line_q      <= '0;
      todo_q      <= '0;
      wait_q      <= '0;
      gmask_q     <= '0;
      inv_q       <= '0;
      slot_v_q    <= 1'b0;
      slot_op_q   <= OP_RD;
      slot_id_q   <= '0;
      slot_line_q <= '0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      id_q    <= id_d;
      line_q  <= line_d;
      todo_q  <= todo_d;
      wait_q  <= wait_d;
      gmask_q <= gmask_d;
      inv_q   <= inv_d;
      slot_v_q <= slot_v_d;
      if (slot_v_d && !slot_v_q) begin
        slot_op_q   <= slot_op_d;
        slot_id_q   <= slot_id_d;
        slot_line_q <= slot_line_d;
      end
    end
  end

  // ---------------- assertions ----------------
  // R4
  inv_only_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    minv_valid |-> rd_pres[minv_id]);

  // R6
  grant_after_fanin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgrant_valid && mgrant_write) |-> (wait_q == '0));

  // R5
  ack_after_fanin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hack_valid |-> ((wait_q == '0) && (todo_q == '0)));

  // R3
  single_home_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid |=> !hreq_valid);

  // R10
  grant_id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgrant_valid |-> (int'(mgrant_id) < NMEM));

  // R11
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_v_q && (st_q != S_IDLE)) |=> (slot_v_q && $stable(slot_line_q)));

  // R11
  slot_full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_v_q && !merge_ok) |-> !mreq_ready);

endmodule

// File: tb/hub_dir_ctrl_test.sv
module hub_dir_ctrl_test;

  localparam int NMEM   = 9;
  localparam int NLINES = 16;
  localparam int IDW    = $clog2(NMEM);
  localparam int LW     = $clog2(NLINES);

  logic           clk;
  logic           rst_n;
  logic           mreq_valid;
  logic           mreq_ready;
  logic [IDW-1:0] mreq_id;
  logic [LW-1:0]  mreq_line;
  logic           mreq_write;
  logic           minv_valid;
  logic [IDW-1:0] minv_id;
  logic [LW-1:0]  minv_line;
  logic           mack_valid;
  logic [IDW-1:0] mack_id;
  logic           mgrant_valid;
  logic [IDW-1:0] mgrant_id;
  logic [LW-1:0]  mgrant_line;
  logic           mgrant_write;
  logic           hinv_valid;
  logic           hinv_ready;
  logic [LW-1:0]  hinv_line;
  logic           evict_valid;
  logic           evict_ready;
  logic [LW-1:0]  evict_line;
  logic           hreq_valid;
  logic [1:0]     hreq_kind;
  logic [LW-1:0]  hreq_line;
  logic           hgrant_valid;
  logic           hack_valid;
  logic [LW-1:0]  hack_line;

  hub_dir_ctrl #(.NMEM(NMEM), .NLINES(NLINES)) uut (
    .clk(clk), .rst_n(rst_n),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_id(mreq_id),
    .mreq_line(mreq_line), .mreq_write(mreq_write),
    .minv_valid(minv_valid), .minv_id(minv_id), .minv_line(minv_line),
    .mack_valid(mack_valid), .mack_id(mack_id),
    .mgrant_valid(mgrant_valid), .mgrant_id(mgrant_id),
    .mgrant_line(mgrant_line), .mgrant_write(mgrant_write),
    .hinv_valid(hinv_valid), .hinv_ready(hinv_ready), .hinv_line(hinv_line),
    .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_line(evict_line),
    .hreq_valid(hreq_valid), .hreq_kind(hreq_kind), .hreq_line(hreq_line),
    .hgrant_valid(hgrant_valid),
    .hack_valid(hack_valid), .hack_line(hack_line)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  // observation logs, filled at falling edges
  int n_minv, n_grant, n_hreq, n_hack;
  int minv_log  [16];
  int grant_log [16];
  int last_gw, last_gline, last_kind, last_hline, last_aline;
  logic [NMEM-1:0] ack_pend;
  logic auto_ack;
  logic man_ack_v;
  logic [IDW-1:0] man_ack_id;

  task automatic clear_logs();
    n_minv = 0; n_grant = 0; n_hreq = 0; n_hack = 0;
    last_gw = -1; last_gline = -1; last_kind = -1; last_hline = -1; last_aline = -1;
  endtask

  always @(negedge clk) begin
    mack_valid = 1'b0;
    mack_id    = '0;
    if (man_ack_v) begin
      mack_valid = 1'b1;
      mack_id    = man_ack_id;
      man_ack_v  = 1'b0;
    end else if (auto_ack && ack_pend != '0) begin
      for (int i = NMEM - 1; i >= 0; i--) begin
        if (ack_pend[i]) mack_id = IDW'(i);
      end
      mack_valid = 1'b1;
      ack_pend[mack_id] = 1'b0;
    end
    if (rst_n) begin
      if (minv_valid) begin
        if (n_minv < 16) minv_log[n_minv] = int'(minv_id);
        n_minv++;
        ack_pend[minv_id] = 1'b1;
      end
      if (mgrant_valid) begin
        if (n_grant < 16) grant_log[n_grant] = int'(mgrant_id);
        n_grant++;
        last_gw    = int'(mgrant_write);
        last_gline = int'(mgrant_line);
      end
      if (hreq_valid) begin
        n_hreq++;
        last_kind  = int'(hreq_kind);
        last_hline = int'(hreq_line);
      end
      if (hack_valid) begin
        n_hack++;
        last_aline = int'(hack_line);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mreq_valid = 1'b0; mreq_id = '0; mreq_line = '0; mreq_write = 1'b0;
    hinv_valid = 1'b0; hinv_line = '0;
    evict_valid = 1'b0; evict_line = '0;
    hgrant_valid = 1'b0;
    auto_ack = 1'b1; man_ack_v = 1'b0; ack_pend = '0;
    cycles(3);
    rst_n = 1'b1;
    clear_logs();
    cycles(1);
  endtask

  task automatic send_req(input int id, input int line, input bit wr);
    mreq_valid = 1'b1;
    mreq_id    = IDW'(id);
    mreq_line  = LW'(line);
    mreq_write = wr;
    forever begin
      #1;
      if (mreq_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    mreq_valid = 1'b0;
  endtask

  task automatic send_hinv(input int line);
    hinv_valid = 1'b1;
    hinv_line  = LW'(line);
    forever begin
      #1;
      if (hinv_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    hinv_valid = 1'b0;
  endtask

  task automatic send_evict(input int line);
    evict_valid = 1'b1;
    evict_line  = LW'(line);
    forever begin
      #1;
      if (evict_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    evict_valid = 1'b0;
  endtask

  task automatic home_grant();
    hgrant_valid = 1'b1;
    @(negedge clk);
    hgrant_valid = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    chk("R11", "ready after reset", int'(mreq_ready), 1);
    chk("R4", "minv idle after reset", int'(minv_valid), 0);
    chk("R3", "hreq idle after reset", int'(hreq_valid), 0);
    chk("R2", "grant idle after reset", int'(mgrant_valid), 0);
    chk("R5", "hack idle after reset", int'(hack_valid), 0);
  endtask

  task automatic t_read_miss_hit_inval();
    do_reset();
    send_req(0, 3, 1'b0);
    cycles(4);
    chk("R3", "miss sends one home msg", n_hreq, 1);
    chk("R3", "home msg kind read", last_kind, 0);
    chk("R3", "home msg line", last_hline, 3);
    chk("R3", "no grant before home reply", n_grant, 0);
    clear_logs();
    home_grant();
    cycles(8);
    chk("R3", "grant after home reply", n_grant, 1);
    chk("R3", "grant to requester", grant_log[0], 0);
    chk("R3", "grant is read", last_gw, 0);
    clear_logs();
    send_req(1, 3, 1'b0);
    cycles(8);
    chk("R2", "hit grant count", n_grant, 1);
    chk("R2", "hit grant target", grant_log[0], 1);
    chk("R2", "hit sends no home msg", n_hreq, 0);
    chk("R2", "hit sends no invalidation", n_minv, 0);
    clear_logs();
    send_hinv(3);
    cycles(12);
    chk("R4", "fan-out count", n_minv, 2);
    chk("R4", "first target", minv_log[0], 0);
    chk("R4", "second target", minv_log[1], 1);
    chk("R4", "single ack", n_hack, 1);
    chk("R4", "ack line", last_aline, 3);
    clear_logs();
    send_req(2, 3, 1'b0);
    cycles(4);
    chk("R4", "entry cleared, read misses", n_hreq, 1);
  endtask

  task automatic t_hinv_empty();
    do_reset();
    send_hinv(5);
    cycles(8);
    chk("R5", "no invalidation sent", n_minv, 0);
    chk("R5", "ack returned", n_hack, 1);
    chk("R5", "ack line", last_aline, 5);
  endtask

  task automatic t_write_paths();
    do_reset();
    send_req(2, 7, 1'b0);
    cycles(4);
    home_grant();
    cycles(8);
    send_req(4, 7, 1'b0);
    cycles(8);
    clear_logs();
    send_req(4, 7, 1'b1);
    cycles(4);
    chk("R6", "unowned write home msg", n_hreq, 1);
    chk("R6", "home msg kind write", last_kind, 1);
    chk("R6", "no grant yet", n_grant, 0);
    home_grant();
    cycles(10);
    chk("R6", "other sharer invalidated", n_minv, 1);
    chk("R6", "invalidated member", minv_log[0], 2);
    chk("R6", "write grant count", n_grant, 1);
    chk("R6", "write grant target", grant_log[0], 4);
    chk("R6", "grant is write", last_gw, 1);
    clear_logs();
    send_req(6, 7, 1'b0);
    cycles(10);
    chk("R8", "modifier invalidated", n_minv, 1);
    chk("R1", "only the writer held the line", minv_log[0], 4);
    chk("R8", "read grant target", grant_log[0], 6);
    chk("R8", "read grant kind", last_gw, 0);
    chk("R8", "no home msg", n_hreq, 0);
    clear_logs();
    send_req(1, 7, 1'b0);
    cycles(8);
    chk("R2", "clean hit no invalidation", n_minv, 0);
    chk("R2", "clean hit grant", n_grant, 1);
    clear_logs();
    send_req(6, 7, 1'b1);
    cycles(10);
    chk("R7", "owned write no home msg", n_hreq, 0);
    chk("R7", "local sharer invalidated", n_minv, 1);
    chk("R7", "invalidated member", minv_log[0], 1);
    chk("R7", "write grant target", grant_log[0], 6);
    chk("R7", "grant is write", last_gw, 1);
    clear_logs();
    send_evict(7);
    cycles(10);
    chk("R9", "member copy invalidated", n_minv, 1);
    chk("R9", "invalidated member", minv_log[0], 6);
    chk("R9", "evict notice count", n_hreq, 1);
    chk("R9", "notice kind evict", last_kind, 2);
    chk("R9", "notice line", last_hline, 7);
    clear_logs();
    send_req(0, 7, 1'b0);
    cycles(4);
    chk("R9", "evicted line misses", n_hreq, 1);
    chk("R9", "miss kind read", last_kind, 0);
  endtask

  task automatic t_bad_ids();
    do_reset();
    send_req(12, 2, 1'b0);
    cycles(10);
    chk("R10", "bad id no home msg", n_hreq, 0);
    chk("R10", "bad id no grant", n_grant, 0);
    send_req(0, 2, 1'b0);
    cycles(4);
    home_grant();
    cycles(8);
    auto_ack = 1'b0;
    clear_logs();
    send_hinv(2);
    cycles(6);
    chk("R10", "invalidation issued", n_minv, 1);
    man_ack_id = IDW'(15);
    man_ack_v  = 1'b1;
    cycles(6);
    chk("R10", "bad ack does not finish", n_hack, 0);
    man_ack_id = IDW'(0);
    man_ack_v  = 1'b1;
    cycles(6);
    chk("R10", "good ack finishes", n_hack, 1);
    auto_ack = 1'b1;
    ack_pend = '0;
  endtask

  task automatic t_merge();
    do_reset();
    send_req(0, 9, 1'b0);
    cycles(3);
    send_req(3, 9, 1'b0);
    cycles(3);
    chk("R3", "merged read adds no home msg", n_hreq, 1);
    home_grant();
    cycles(10);
    chk("R3", "merged grants", n_grant, 2);
    chk("R3", "first merged grant", grant_log[0], 0);
    chk("R3", "second merged grant", grant_log[1], 3);
    chk("R3", "still one home msg", n_hreq, 1);
  endtask

  task automatic t_pending_slot();
    do_reset();
    send_req(0, 1, 1'b0);
    cycles(3);
    send_req(1, 2, 1'b0);
    cycles(1);
    mreq_valid = 1'b1;
    mreq_id    = IDW'(2);
    mreq_line  = LW'(4);
    mreq_write = 1'b0;
    #1;
    chk("R11", "ready low while slot full", int'(mreq_ready), 0);
    mreq_valid = 1'b0;
    cycles(2);
    chk("R11", "slot not sent early", n_hreq, 1);
    home_grant();
    cycles(10);
    chk("R11", "first request granted", grant_log[0], 0);
    chk("R11", "slot request sent home", n_hreq, 2);
    chk("R11", "slot request line", last_hline, 2);
    home_grant();
    cycles(10);
    chk("R11", "slot request granted", n_grant, 2);
    chk("R11", "slot grant target", grant_log[1], 1);
  endtask

  initial begin
    rst_n = 1'b0;
    mreq_valid = 1'b0; mreq_id = '0; mreq_line = '0; mreq_write = 1'b0;
    hinv_valid = 1'b0; hinv_line = '0;
    evict_valid = 1'b0; evict_line = '0;
    hgrant_valid = 1'b0;
    auto_ack = 1'b1; man_ack_v = 1'b0; man_ack_id = '0; ack_pend = '0;
    clear_logs();
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset_state();
    t_read_miss_hit_inval();
    t_hinv_empty();
    t_write_paths();
    t_bad_ids();
    t_merge();
    t_pending_slot();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=0 cycles left", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule